// File: doc/BRIEF.md
# Hypercube Dimension-Ordered Route Generator

This block works out the path a message takes through a binary hypercube whose node count is two to the power of a `DIMS` parameter (8 by default, so 256 nodes). Each node carries a binary label. Two nodes share a link only when their labels differ in a single bit. A route request carries a source and a destination label and is offered through a valid/ready start handshake. The block XORs the two labels to form a route vector, and the number of set bits in that vector is the hop distance. It then walks the path by flipping one set bit of the vector at a time. The scan runs from the top bit downward, and once a bit has been flipped, only lower positions remain in play.

Each hop is offered on a valid/ready output as the address of the next node, together with the index of the dimension it crosses and a flag marking the final hop. The output stalls while the consumer withholds ready. A one-cycle done pulse closes every route. A separate combinational lookup port returns the single next step from any current node toward any target, so a switch can decide its output link locally without running a whole route.

Top module: `hypercube_ecube_router`

## Requirements
- R1: During and straight after reset, startReady is 1, hopValid is 0, done is 0 and distance is 0.
- R2: From the cycle after a start is accepted until the next start is accepted, distance equals the number of set bits in srcAddr XOR dstAddr.
- R3: Each hop address is the previous node (the source for the first hop) with exactly one bit flipped. That bit is the highest set bit of the route vector not yet used, and the final hop equals the destination. With 8 dimensions, 0x86 to 0xD7 yields 0xC6, 0xD6, 0xD7.
- R4: hopDim is the index (0 = least significant) of the bit the hop flips, and it falls strictly from one hop to the next within a route.
- R5: hopLast is 1 on the final hop of a route and 0 on every other hop.
- R6: While hopValid is 1 and hopReady is 0, hopValid, hopAddr, hopDim and hopLast hold their values into the next cycle.
- R7: When srcAddr equals dstAddr, no hop is offered, distance reads 0 and done is 1 in the cycle after the start is accepted.
- R8: done is a single-cycle pulse in the cycle after the final hop is taken (hopValid, hopReady and hopLast all 1), with hopValid 0 in that cycle.
- R9: startReady is 1 only when no route is in progress and done is not pulsing. A startValid raised while startReady is 0 has no effect on the hops, distance or done of the route in progress.
- R10: peekNext equals peekNode with the highest set bit of peekNode XOR peekDest flipped, and peekDim gives that bit's index. When the two labels are equal, peekNext equals peekNode and peekDim is 0.
- R11: After a start with differing labels, hopValid is 1 in the next cycle and stays 1 on every cycle up to and including the final hop being taken. This gives one hop per cycle while hopReady stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startValid | input | 1 | A route request is offered |
| startReady | output | 1 | Block is idle and accepts a request |
| srcAddr | input | DIMS | Source node label |
| dstAddr | input | DIMS | Destination node label |
| hopValid | output | 1 | A hop is offered |
| hopReady | input | 1 | Consumer takes the offered hop |
| hopAddr | output | DIMS | Label of the node reached by this hop |
| hopDim | output | max(1,clog2(DIMS)) | Dimension index crossed by this hop |
| hopLast | output | 1 | This hop reaches the destination |
| distance | output | clog2(DIMS+1) | Hop count of the latest accepted route |
| done | output | 1 | One-cycle pulse at the end of a route |
| peekNode | input | DIMS | Current node for the lookup port |
| peekDest | input | DIMS | Target node for the lookup port |
| peekNext | output | DIMS | Next node on the dimension-ordered path |
| peekDim | output | max(1,clog2(DIMS)) | Dimension crossed by that step |

## Verification
The hardest case to reach from the ports is a start request that arrives while a route is still being walked or while done is pulsing. The correct outcome is that nothing changes, so it can only be seen by watching later hops. The stimulus therefore raises startValid with unrelated labels for the first cycles of each route, including the cycle where done is high for a same-node request. Meanwhile hopReady is dropped at random, so the stall path and the ignored request overlap. A behavioural model that recomputes each route as a queue of hops is compared against the outputs on every cycle, so any hop that an ignored request disturbed would show up as a mismatch.

// File: rtl/ecube_pkg.sv
package ecube_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOP  = 2'd1,
    ST_DONE = 2'd2
  } ecube_state_t;

  typedef struct packed {
    logic loadRoute;
    logic stepHop;
  } ecube_strobe_t;

endpackage

// File: rtl/ecube_next_hop.sv
module ecube_next_hop #(
  parameter int DIMS = 8,
  localparam int IW = (DIMS > 1) ? $clog2(DIMS) : 1
) (
  input  logic [DIMS-1:0] hereNode,
  input  logic [DIMS-1:0] thereNode,
  output logic [DIMS-1:0] stepNode,
  output logic [IW-1:0]   stepDim,
  output logic            anyLeft,
  output logic            finalStep
);

  logic [DIMS-1:0] routeVec;
  logic [DIMS-1:0] flipMask;

  assign routeVec = hereNode ^ thereNode;

  // Highest set bit wins: later (higher) indices overwrite earlier ones.
  always_comb begin
    stepDim = '0;
    anyLeft = 1'b0;
    for (int i = 0; i < DIMS; i++) begin
      if (routeVec[i]) begin
        stepDim = IW'(i);
        anyLeft = 1'b1;
      end
    end
  end

  assign flipMask  = anyLeft ? (DIMS'(1) << stepDim) : '0;
  assign stepNode  = hereNode ^ flipMask;
  assign finalStep = anyLeft && ((routeVec & ~flipMask) == '0);

endmodule

// File: rtl/ecube_datapath.sv
module ecube_datapath
  import ecube_pkg::*;
#(
  parameter int DIMS = 8,
  localparam int IW = (DIMS > 1) ? $clog2(DIMS) : 1,
  localparam int DW = $clog2(DIMS + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ecube_strobe_t   strobe,
  input  logic [DIMS-1:0] srcAddr,
  input  logic [DIMS-1:0] dstAddr,
  output logic            sameNode,
  output logic            hopLast,
  output logic [DIMS-1:0] hopAddr,
  output logic [IW-1:0]   hopDim,
  output logic [DW-1:0]   distance
);

  logic [DIMS-1:0] curNode;
  logic [DIMS-1:0] targetNode;
  logic [DW-1:0]   newDistance;
  logic [DIMS-1:0] newVec;
  logic            unusedAny;

  assign newVec   = srcAddr ^ dstAddr;
  assign sameNode = (newVec == '0);

  always_comb begin
    newDistance = '0;
    for (int i = 0; i < DIMS; i++) begin
      newDistance = newDistance + DW'(newVec[i]);
    end
  end

  ecube_next_hop #(.DIMS(DIMS)) i_walk (
    .hereNode (curNode),
    .thereNode(targetNode),
    .stepNode (hopAddr),
    .stepDim  (hopDim),
    .anyLeft  (unusedAny),
    .finalStep(hopLast)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curNode    <= '0;
      targetNode <= '0;
      distance   <= '0;
    end else if (strobe.loadRoute) begin
      curNode    <= srcAddr;
      targetNode <= dstAddr;
      distance   <= newDistance;
    end else if (strobe.stepHop) begin
      curNode    <= hopAddr;
    end
  end

endmodule

// File: rtl/ecube_ctrl.sv
module ecube_ctrl
  import ecube_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startValid,
  input  logic          hopReady,
  input  logic          sameNode,
  input  logic          hopLast,
  output ecube_strobe_t strobe,
  output logic          startReady,
  output logic          hopValid,
  output logic          done
);

  ecube_state_t state, stateNext;

  always_comb begin
    stateNext        = state;
    strobe.loadRoute = 1'b0;
    strobe.stepHop   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          strobe.loadRoute = 1'b1;
          stateNext        = sameNode ? ST_DONE : ST_HOP;
        end
      end
      ST_HOP: begin
        if (hopReady) begin
          strobe.stepHop = 1'b1;
          if (hopLast) stateNext = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign startReady = (state == ST_IDLE);
  assign hopValid   = (state == ST_HOP);
  assign done       = (state == ST_DONE);

endmodule

// File: rtl/hypercube_ecube_router.sv
module hypercube_ecube_router
  import ecube_pkg::*;
#(
  parameter int DIMS = 8,
  localparam int IW = (DIMS > 1) ? $clog2(DIMS) : 1,
  localparam int DW = $clog2(DIMS + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  output logic            startReady,
  input  logic [DIMS-1:0] srcAddr,
  input  logic [DIMS-1:0] dstAddr,
  output logic            hopValid,
  input  logic            hopReady,
  output logic [DIMS-1:0] hopAddr,
  output logic [IW-1:0]   hopDim,
  output logic            hopLast,
  output logic [DW-1:0]   distance,
  output logic            done,
  input  logic [DIMS-1:0] peekNode,
  input  logic [DIMS-1:0] peekDest,
  output logic [DIMS-1:0] peekNext,
  output logic [IW-1:0]   peekDim
);

  ecube_strobe_t strobe;
  logic          sameNode;
  logic          lastStep;
  logic          peekAny;
  logic          peekFinal;

  ecube_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .hopReady  (hopReady),
    .sameNode  (sameNode),
    .hopLast   (lastStep),
    .strobe    (strobe),
    .startReady(startReady),
    .hopValid  (hopValid),
    .done      (done)
  );

  ecube_datapath #(.DIMS(DIMS)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcAddr (srcAddr),
    .dstAddr (dstAddr),
    .sameNode(sameNode),
    .hopLast (lastStep),
    .hopAddr (hopAddr),
    .hopDim  (hopDim),
    .distance(distance)
  );

  assign hopLast = hopValid && lastStep;

  ecube_next_hop #(.DIMS(DIMS)) i_peek (
    .hereNode (peekNode),
    .thereNode(peekDest),
    .stepNode (peekNext),
    .stepDim  (peekDim),
    .anyLeft  (peekAny),
    .finalStep(peekFinal)
  );

  // Lookup flags have no port of their own; fold them into a dead term.
  logic peekUnused;
  assign peekUnused = peekAny ^ peekFinal;

endmodule

// File: rtl/ecube_router_checker.sv
module ecube_router_checker #(
  parameter int DIMS = 8,
  localparam int IW = (DIMS > 1) ? $clog2(DIMS) : 1,
  localparam int DW = $clog2(DIMS + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            startValid,
  input logic            startReady,
  input logic [DIMS-1:0] srcAddr,
  input logic [DIMS-1:0] dstAddr,
  input logic            hopValid,
  input logic            hopReady,
  input logic [DIMS-1:0] hopAddr,
  input logic [IW-1:0]   hopDim,
  input logic            hopLast,
  input logic [DW-1:0]   distance,
  input logic            done
);

  logic startTaken, hopTaken;
  assign startTaken = startValid && startReady;
  assign hopTaken   = hopValid && hopReady;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> startReady && !hopValid && !done && distance == '0);

  assert_distance_R2: assert property (@(posedge clk) disable iff (!rstN)
    startTaken |=> distance == DW'($countones($past(srcAddr) ^ $past(dstAddr))));

  assert_one_bit_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    hopTaken && !hopLast |=> $countones(hopAddr ^ $past(hopAddr)) == 1);

  assert_dim_falls_R4: assert property (@(posedge clk) disable iff (!rstN)
    hopTaken && !hopLast |=> hopDim < $past(hopDim));

  assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    hopLast |-> hopValid);

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    hopValid && !hopReady |=> hopValid && $stable(hopAddr) && $stable(hopDim) && $stable(hopLast));

  assert_same_node_R7: assert property (@(posedge clk) disable iff (!rstN)
    startTaken && (srcAddr == dstAddr) |=> done && !hopValid && distance == '0);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    hopTaken && hopLast |=> done && !hopValid);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    startReady |-> !hopValid && !done);

  assert_first_hop_R11: assert property (@(posedge clk) disable iff (!rstN)
    startTaken && (srcAddr != dstAddr) |=> hopValid);

  assert_back_to_back_R11: assert property (@(posedge clk) disable iff (!rstN)
    hopTaken && !hopLast |=> hopValid);

endmodule

bind hypercube_ecube_router ecube_router_checker #(.DIMS(DIMS)) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startValid(startValid),
  .startReady(startReady),
  .srcAddr   (srcAddr),
  .dstAddr   (dstAddr),
  .hopValid  (hopValid),
  .hopReady  (hopReady),
  .hopAddr   (hopAddr),
  .hopDim    (hopDim),
  .hopLast   (hopLast),
  .distance  (distance),
  .done      (done)
);

// File: tb/test_hypercube_ecube_router.sv
`timescale 1ns/1ps
module test_hypercube_ecube_router;

  localparam int DIMS = 8;
  localparam int IW = 3;
  localparam int DW = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            startValid = 1'b0;
  logic            startReady;
  logic [DIMS-1:0] srcAddr = '0;
  logic [DIMS-1:0] dstAddr = '0;
  logic            hopValid;
  logic            hopReady = 1'b1;
  logic [DIMS-1:0] hopAddr;
  logic [IW-1:0]   hopDim;
  logic            hopLast;
  logic [DW-1:0]   distance;
  logic            done;
  logic [DIMS-1:0] peekNode = '0;
  logic [DIMS-1:0] peekDest = '0;
  logic [DIMS-1:0] peekNext;
  logic [IW-1:0]   peekDim;

  always #2.5 clk = ~clk;

  hypercube_ecube_router #(.DIMS(DIMS)) i_hypercube_ecube_router (.*);

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 idle, 1 walking, 2 done pulse
  int mState = 0;
  int mDist = 0;
  int mHop[$];
  int mDim[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mDist = 0; mHop.delete(); mDim.delete();
    end else begin
      case (mState)
        0: if (startValid) begin
          int node, vec;
          node = srcAddr; vec = srcAddr ^ dstAddr; mDist = 0;
          mHop.delete(); mDim.delete();
          for (int b = DIMS - 1; b >= 0; b--) begin
            if (vec[b]) begin
              node = node ^ (1 << b);
              mHop.push_back(node); mDim.push_back(b); mDist++;
            end
          end
          mState = (mHop.size() == 0) ? 2 : 1;
        end
        1: if (hopReady) begin
          void'(mHop.pop_front()); void'(mDim.pop_front());
          if (mHop.size() == 0) mState = 2;
        end
        default: mState = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(startReady == (mState == 0), "R9 startReady", startReady, mState == 0);
      chk(hopValid == (mState == 1), "R11 hopValid", hopValid, mState == 1);
      chk(done == (mState == 2), "R8/R7 done", done, mState == 2);
      chk(distance == mDist, "R2 distance", distance, mDist);
      if (mState == 1) begin
        chk(hopAddr == mHop[0], "R3 hopAddr", hopAddr, mHop[0]);
        chk(hopDim == mDim[0], "R4 hopDim", hopDim, mDim[0]);
        chk(hopLast == (mHop.size() == 1), "R5 hopLast", hopLast, mHop.size() == 1);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      chk(1'b0, "watchdog", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // R9: optional junk start requests while busy; randomReady stalls the output (R6)
  task automatic runRoute(input int s, input int d, input bit randomReady, input bit junk);
    int n;
    @(negedge clk);
    while (!startReady) @(negedge clk);
    startValid = 1'b1; srcAddr = DIMS'(s); dstAddr = DIMS'(d);
    hopReady = randomReady ? 1'($urandom % 2) : 1'b1;
    @(negedge clk);
    n = 0;
    startValid = 1'b0;
    while (!startReady) begin
      hopReady = randomReady ? 1'($urandom % 2) : 1'b1;
      if (junk && n < 3) begin
        startValid = 1'b1; srcAddr = DIMS'($urandom); dstAddr = DIMS'($urandom);
      end else begin
        startValid = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    startValid = 1'b0;
  endtask

  function automatic int refStep(input int node, input int dest, output int dim);
    int vec;
    vec = node ^ dest; dim = 0;
    for (int b = DIMS - 1; b >= 0; b--) begin
      if (vec[b]) begin
        dim = b;
        return node ^ (1 << b);
      end
    end
    return node;
  endfunction

  task automatic peekCheck(input int n, input int d);
    int expNode, expDim;
    peekNode = DIMS'(n); peekDest = DIMS'(d);
    #1;
    expNode = refStep(n, d, expDim);
    chk(peekNext == DIMS'(expNode), "R10 peekNext", peekNext, expNode);
    chk(peekDim == IW'(expDim), "R10 peekDim", peekDim, expDim);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(startReady == 1'b1, "R1 startReady", startReady, 1);
    chk(hopValid == 1'b0, "R1 hopValid", hopValid, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(distance == '0, "R1 distance", distance, 0);
    rstN = 1'b1;
    @(negedge clk);

    runRoute(8'h86, 8'hD7, 1'b0, 1'b0); // R3 worked example
    runRoute(8'h5A, 8'h5A, 1'b0, 1'b1); // R7 same node with junk during done
    runRoute(8'h00, 8'hFF, 1'b0, 1'b0); // R11 full-length burst
    runRoute(8'hFF, 8'h00, 1'b1, 1'b1); // R6 stalls plus R9 junk
    runRoute(8'h10, 8'h11, 1'b1, 1'b0); // single hop, R5
    runRoute(8'h80, 8'h00, 1'b0, 1'b1);
    for (int k = 0; k < 200; k++) begin
      runRoute($urandom % 256, $urandom % 256, k[0], k[1]);
    end

    peekCheck(8'h86, 8'hD7);
    peekCheck(8'hC6, 8'hD7);
    peekCheck(8'hD6, 8'hD7);
    peekCheck(8'h3C, 8'h3C);
    peekCheck(8'h00, 8'h01);
    for (int k = 0; k < 40; k++) peekCheck($urandom % 256, $urandom % 256);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule